// File: doc/BRIEF.md
# Synchronous-Serial Position Transmitter

This block is the slave end of a clocked synchronous-serial position link. An external master toggles a clock line. Each rising edge of that clock moves one bit of a position word onto the serial data output. The block runs on a fast local system clock. It brings the master clock into that domain and detects its rising edges there. On the first edge of a burst it freezes a copy of the live count together with two active-low status flags, then shifts that copy out.

If the master keeps clocking, the word repeats until a fixed frame length has been sent. After that the line stays low. Once the master clock has been quiet for a programmable number of system clocks, the line returns high. A high line tells the master that a fresh word is ready. A filtered protocol-select input enables or disables the whole transmitter. A floating select pin is modelled as a high level, which selects this serial mode.

Top module: `ssi_pos_tx`

## Requirements
- R1: After reset the data output `sd_out` is high and the serial mode is enabled.
- R2: The first master-clock rising edge after idle captures `{cnt_in, err_n, warn_n}` and drives the count MSB onto `sd_out`.
- R3: `sd_out` changes only in response to a master-clock rising edge, a timeout or a mode change. It stays stable while the master clock is high and while it is low.
- R4: One word is `CNT_W` count bits, MSB first, then `err_n`, then `warn_n`, one bit per rising edge.
- R5: Changes on `cnt_in`, `err_n` or `warn_n` after the first edge of a burst do not alter the bits sent in that burst.
- R6: While the clock keeps running with no timeout, the word is resent from its MSB after `warn_n`, for `FRAME_BITS` (94) bits in total.
- R7: Rising edges after bit `FRAME_BITS` drive `sd_out` low, and it stays low until the timeout.
- R8: `TMO_CYC` system clocks with no rising edge end the burst. `sd_out` then goes high, and the next edge starts a new word from a fresh capture.
- R9: When `sel_in` is low for `FILT_CYC` consecutive synchronised cycles, the serial mode turns off. `sd_out` is then high and master-clock edges are ignored. A shorter low pulse has no effect.
- R10: When `sel_in` is high again for `FILT_CYC` cycles, the serial mode turns back on and bursts work as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ma_in | input | 1 | Master serial clock, asynchronous |
| sel_in | input | 1 | Protocol select, high (open) selects serial mode |
| cnt_in | input | CNT_W | Live counter value |
| err_n | input | 1 | Error flag, active low |
| warn_n | input | 1 | Warning flag, active low |
| sd_out | output | 1 | Serial data line |

## Verification
A wrong bit pointer or word register shows up at the port on the very next master edge. A bit that is out of order, stale or repeated appears as a mismatch against the value the bench computed for that position. A timeout counter that never fires keeps the line low past the quiet window, and one that fires early raises it in the middle of a word. Either fault is seen within one timeout period. A broken select filter either ignores a long low level or reacts to a short glitch. The bench sees this as the line staying high, or not, across a following burst.

// File: rtl/ssi_pos_tx.sv
module ssi_pos_tx #(
  parameter int CNT_W      = 24,
  parameter int FRAME_BITS = 94,
  parameter int TMO_CYC    = 800,
  parameter int FILT_CYC   = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ma_in,
  input  logic             sel_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             err_n,
  input  logic             warn_n,
  output logic             sd_out
);
  localparam int WORD_W = CNT_W + 2;
  localparam int POS_W  = $clog2(FRAME_BITS + 1);
  localparam int TMO_W  = $clog2(TMO_CYC + 1);
  localparam int FILT_W = $clog2(FILT_CYC + 1);

  logic ma_s1, ma_s2, ma_d;
  logic sel_s1, sel_s2;
  logic mode_ssi;
  logic [FILT_W-1:0] fcnt;
  logic active;
  logic [POS_W-1:0] pos;
  logic [TMO_W-1:0] tmo;
  logic [WORD_W-1:0] sreg;
  logic [WORD_W-1:0] snap;
  logic ma_rise;

  assign snap    = {cnt_in, err_n, warn_n};
  assign ma_rise = ma_s2 & ~ma_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_s1 <= 1'b0; ma_s2 <= 1'b0; ma_d <= 1'b0;
      sel_s1 <= 1'b1; sel_s2 <= 1'b1;
    end else begin
      ma_s1 <= ma_in; ma_s2 <= ma_s1; ma_d <= ma_s2;
      sel_s1 <= sel_in; sel_s2 <= sel_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ssi <= 1'b1;
      fcnt     <= '0;
    end else if (sel_s2 == mode_ssi) begin
      fcnt <= '0;
    end else if (fcnt == FILT_W'(FILT_CYC - 1)) begin
      mode_ssi <= sel_s2;
      fcnt     <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      tmo    <= '0;
      sreg   <= '0;
      sd_out <= 1'b1;
    end else if (!mode_ssi) begin
      active <= 1'b0;
      pos    <= '0;
      tmo    <= '0;
      sd_out <= 1'b1;
    end else if (ma_rise) begin
      tmo    <= '0;
      active <= 1'b1;
      if (!active) begin
        sd_out <= snap[WORD_W-1];
        sreg   <= {snap[WORD_W-2:0], snap[WORD_W-1]};
        pos    <= POS_W'(1);
      end else if (pos < POS_W'(FRAME_BITS)) begin
        sd_out <= sreg[WORD_W-1];
        sreg   <= {sreg[WORD_W-2:0], sreg[WORD_W-1]};
        pos    <= pos + 1'b1;
      end else begin
        sd_out <= 1'b0;
      end
    end else if (active) begin
      if (tmo == TMO_W'(TMO_CYC - 1)) begin
        active <= 1'b0;
        pos    <= '0;
        tmo    <= '0;
        sd_out <= 1'b1;
      end else begin
        tmo <= tmo + 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> sd_out && mode_ssi); // R1
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ssi && !ma_rise && active && tmo != TMO_W'(TMO_CYC - 1) && sel_s2 == mode_ssi) |=> $stable(sd_out)); // R3
  AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) pos <= POS_W'(FRAME_BITS)); // R6
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ssi && active && ma_rise && pos == POS_W'(FRAME_BITS) && sel_s2 == mode_ssi) |=> !sd_out); // R7
  AST_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(active) |-> sd_out); // R8
  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !mode_ssi |=> sd_out && !active); // R9
endmodule

// File: tb/tb_ssi_pos_tx.sv
module tb_ssi_pos_tx;
  localparam int CNT_W = 24;
  localparam int WW    = CNT_W + 2;
  localparam int FRAME = 94;
  localparam int TMO   = 40;
  localparam int FILT  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ma_in = 1'b0;
  logic sel_in = 1'b1;
  logic [CNT_W-1:0] cnt_in = '0;
  logic err_n = 1'b1, warn_n = 1'b1;
  logic sd_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssi_pos_tx #(.CNT_W(CNT_W), .FRAME_BITS(FRAME), .TMO_CYC(TMO), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .ma_in(ma_in), .sel_in(sel_in),
    .cnt_in(cnt_in), .err_n(err_n), .warn_n(warn_n), .sd_out(sd_out));

  function automatic logic exp_bit(input logic [WW-1:0] w, input int n);
    if (n >= FRAME) return 1'b0;
    return w[WW-1-(n % WW)];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic edge_pulse(output logic hi_s, output logic lo_s);
    @(negedge clk) ma_in = 1'b1;
    repeat (6) @(negedge clk);
    hi_s = sd_out;
    ma_in = 1'b0;
    repeat (6) @(negedge clk);
    lo_s = sd_out;
  endtask

  task automatic new_word(output logic [WW-1:0] w);
    @(negedge clk);
    cnt_in = CNT_W'($urandom);
    err_n  = 1'($urandom);
    warn_n = 1'($urandom);
    w = {cnt_in, err_n, warn_n};
  endtask

  // bursts of n edges; inputs scrambled after each edge (R5)
  task automatic burst(input int n, input logic [WW-1:0] w);
    logic h, l;
    for (int i = 0; i < n; i++) begin
      edge_pulse(h, l);
      if (i == 0) check("R2 first bit", h, exp_bit(w, 0));
      else if (i < WW) check("R4/R5 word bit", h, exp_bit(w, i));
      else if (i < FRAME) check("R6 repeat bit", h, exp_bit(w, i));
      else check("R7 tail low", h, 1'b0);
      check("R3 hold while low", l, h);
      cnt_in = CNT_W'($urandom); err_n = 1'($urandom); warn_n = 1'($urandom);
    end
  endtask

  task automatic quiet(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [WW-1:0] w;
    logic h, l;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset line", sd_out, 1'b1);
    rst_n = 1'b1;
    quiet(4);
    check("R1 idle after reset", sd_out, 1'b1);

    new_word(w); burst(WW, w);
    quiet(TMO + 10); check("R8 idle after word", sd_out, 1'b1);

    for (int k = 0; k < 6; k++) begin
      new_word(w); burst(1 + int'($urandom % 40), w);
      quiet(TMO + 10); check("R8 timeout high", sd_out, 1'b1);
    end

    new_word(w); burst(FRAME + 3, w);
    quiet(TMO - 20); check("R7 low before timeout", sd_out, 1'b0);
    quiet(30); check("R8 high after tail", sd_out, 1'b1);

    new_word(w); burst(5, w);
    quiet(TMO + 10); check("R8 mid-word timeout", sd_out, 1'b1);
    new_word(w); burst(3, w);
    quiet(TMO + 10);

    @(negedge clk) sel_in = 1'b0;
    quiet(FILT - 6);
    sel_in = 1'b1;
    quiet(4);
    new_word(w); burst(4, w);
    quiet(TMO + 10);

    @(negedge clk) sel_in = 1'b0;
    quiet(FILT + 10);
    check("R9 off line high", sd_out, 1'b1);
    edge_pulse(h, l);
    check("R9 edge ignored hi", h, 1'b1);
    check("R9 edge ignored lo", l, 1'b1);
    edge_pulse(h, l);
    check("R9 edge ignored 2", h, 1'b1);

    @(negedge clk) sel_in = 1'b1;
    quiet(FILT + 10);
    check("R10 back idle", sd_out, 1'b1);
    new_word(w); burst(WW + 2, w);
    quiet(TMO + 10); check("R10 end high", sd_out, 1'b1);

    summary();
  end
endmodule